// File: doc/BRIEF.md
# UART Loopback Fault Injector

This block sits on the internal loopback path of a UART. Between the transmitter's serial output and the receiver's serial input it can inject faults on purpose, so that the receiver's error detection can be tested without any external wiring. It can add a fixed delay in sample-clock slots. It can invert one oversample per bit to test the receiver's majority vote. It can flip the parity bit of each frame. It can also force the stop bit low and then hold the line low for ten bit times, which produces a framing error followed by a break.

The transmitter's baud generator supplies the timing. A one-clock `tick_i` strobe starts each sample slot. `bit_kind_i` tells which bit of the frame the slot belongs to, and `center_i` marks the bit-center slot. All fault logic works in whole sample slots. The looped-back value is registered, and it changes only in the clock after a tick.

A single control word configures the block. Injection is armed only when the 4-bit key field holds 0xA.

Top module: `lbf_loopback`

## Requirements
- R1: The control word resets to 0. Its writable fields are: key [3:0], shift [6:4], sample-mask [9:8], parity-inject [12], break-inject [13] and loopback-enable [16]. Every other bit reads 0 and ignores writes, so writing all ones reads back 0x0001337F.
- R2: With loopback-enable at 0, `rx_o` follows `pin_rx_i` combinationally, whatever the other fields hold.
- R3: With loopback-enable at 1 and a key other than 0xA, each tick loads `tx_i` unchanged into `rx_o`, and no fault is applied.
- R4: In test mode (loopback-enable at 1, key 0xA), a shift of s moves every slot outside the start bit to the value presented s ticks earlier, for s from 0 to 7.
- R5: Start-bit slots (`bit_kind_i`=1) are never delayed: each one loads that same slot's `tx_i`.
- R6: In test mode, sample-mask value m (1..3) inverts exactly one slot per frame bit, the slot m-1 ticks after the center slot. Value 0 inverts nothing.
- R7: A single inverted sample never changes a byte decoded by a three-sample majority vote at center-1, center and center+1, and it raises no error.
- R8: With parity-inject set, the looped-back parity bit (`bit_kind_i`=3) is inverted, and the receiver reports a parity error only.
- R9: With break-inject set, the stop-bit slots (`bit_kind_i`=4) loop back as 0, and the receiver reports a framing error.
- R10: After an injected stop bit, the line is held at 0 for exactly 10 bit times (10×OVS slots) and then released.
- R11: In loopback, `rx_o` changes only in the clock that follows a `tick_i` pulse, one clock after the slot's inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Control word read-back |
| tick_i | input | 1 | Start of a sample slot |
| bit_kind_i | input | 3 | Bit position of the slot: 0 idle, 1 start, 2 data, 3 parity, 4 stop |
| center_i | input | 1 | Slot is the bit-center sample |
| tx_i | input | 1 | Transmitter serial output |
| pin_rx_i | input | 1 | External receive pin |
| rx_o | output | 1 | Receiver serial input |

## Verification
The bench targets these corner cases:
- **Start bit under a large delay.** With a shift of 7, a design that delayed the start bit would show idle-high in the first start slot instead of 0.
- **Mask offsets.** Each mask value is compared slot by slot against the ideal waveform. A mask that is off by one slot would invert the wrong sample, and one that inverts more than one slot could break the majority decode.
- **Break length.** The low run after the stop bit is measured to the exact slot. A counter that is one slot short or long, or that never releases the line, shows up as a wrong run length.
- **Wrong key.** A frame sent with faults configured but a wrong key must loop back bit for bit. This catches key decoding that leaks faults.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_START  = 3'd1,
    BK_DATA   = 3'd2,
    BK_PARITY = 3'd3,
    BK_STOP   = 3'd4
  } bit_kind_e;

  localparam int unsigned SHIFT_W   = 3;
  localparam int unsigned MASK_W    = 2;
  localparam int unsigned KEY_LSB   = 0;
  localparam int unsigned SHIFT_LSB = 4;
  localparam int unsigned MASK_LSB  = 8;
  localparam int unsigned PAR_BIT   = 12;
  localparam int unsigned BRK_BIT   = 13;
  localparam int unsigned LOOP_BIT  = 16;
  localparam logic [3:0]  TEST_KEY  = 4'hA;
  localparam logic [31:0] WR_MASK   = 32'h0001_337F;

  typedef struct packed {
    logic               loop_en;
    logic               brk_inj;
    logic               par_inj;
    logic [MASK_W-1:0]  mask;
    logic [SHIFT_W-1:0] shift;
    logic [3:0]         key;
  } cfg_t;
endpackage

// File: rtl/lbf_cfg_reg.sv
module lbf_cfg_reg
  import lbf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output cfg_t        cfg_o
);
  logic [31:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (we_i) word_q <= wdata_i & WR_MASK;
  end

  assign rdata_o       = word_q;
  assign cfg_o.key     = word_q[KEY_LSB +: 4];
  assign cfg_o.shift   = word_q[SHIFT_LSB +: SHIFT_W];
  assign cfg_o.mask    = word_q[MASK_LSB +: MASK_W];
  assign cfg_o.par_inj = word_q[PAR_BIT];
  assign cfg_o.brk_inj = word_q[BRK_BIT];
  assign cfg_o.loop_en = word_q[LOOP_BIT];
endmodule

// File: rtl/lbf_sample_pos.sv
module lbf_sample_pos
  import lbf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              center_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              inv_o
);
  // slots elapsed since the center slot: 0 = none tracked, 1..2 = center+1..+2
  logic [MASK_W-1:0] after_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) after_q <= '0;
    else if (tick_i) begin
      if (center_i)          after_q <= MASK_W'(1);
      else if (after_q == 1) after_q <= MASK_W'(2);
      else                   after_q <= '0;
    end
  end

  always_comb begin
    inv_o = 1'b0;
    if (mask_i != '0) begin
      if (center_i)          inv_o = (mask_i == MASK_W'(1));
      else if (after_q != 0) inv_o = (mask_i == after_q + MASK_W'(1));
    end
  end
endmodule

// File: rtl/lbf_delay.sv
module lbf_delay #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          d_i,
  input  logic [SW-1:0] sel_i,
  output logic          q_o
);
  logic [DEPTH-1:0] line_q;
  logic [SW-1:0]    idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     line_q <= '1;
    else if (tick_i) line_q <= {line_q[DEPTH-2:0], d_i};
  end

  assign idx = sel_i - SW'(1);
  assign q_o = (sel_i == '0) ? d_i : line_q[idx];
endmodule

// File: rtl/lbf_break.sv
module lbf_break #(
  parameter int unsigned SLOTS = 80,
  localparam int unsigned CW = $clog2(SLOTS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic arm_i,
  output logic active_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) begin
      if (arm_i)             cnt_q <= CW'(SLOTS);
      else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end
  end

  assign active_o = (cnt_q != '0) && !arm_i;
endmodule

// File: rtl/lbf_loopback.sv
module lbf_loopback
  import lbf_pkg::*;
#(
  parameter int unsigned OVS      = 8,
  parameter int unsigned BRK_BITS = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        tick_i,
  input  logic [2:0]  bit_kind_i,
  input  logic        center_i,
  input  logic        tx_i,
  input  logic        pin_rx_i,
  output logic        rx_o
);
  localparam int unsigned BRK_SLOTS = OVS * BRK_BITS;
  localparam int unsigned DLY_DEPTH = 1 << SHIFT_W;

  cfg_t      cfg;
  bit_kind_e kind;
  logic      test_on, tx_mod, tx_dly, inv, brk_arm, brk_act, lb_d, lb_q;
  logic [SHIFT_W-1:0] dly_sel;

  assign kind    = bit_kind_e'(bit_kind_i);
  assign test_on = cfg.loop_en && (cfg.key == TEST_KEY);

  lbf_cfg_reg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .cfg_o(cfg)
  );

  // frame-level faults act before the delay line
  always_comb begin
    tx_mod = tx_i;
    if (test_on && cfg.par_inj && kind == BK_PARITY) tx_mod = ~tx_i;
    if (test_on && cfg.brk_inj && kind == BK_STOP)   tx_mod = 1'b0;
  end

  assign dly_sel = test_on ? cfg.shift : '0;

  lbf_delay #(.DEPTH(DLY_DEPTH)) u_dly (
    .clk_i, .rst_ni, .tick_i, .d_i(tx_mod), .sel_i(dly_sel), .q_o(tx_dly)
  );

  lbf_sample_pos u_pos (
    .clk_i, .rst_ni, .tick_i, .center_i, .mask_i(cfg.mask), .inv_o(inv)
  );

  assign brk_arm = test_on && cfg.brk_inj && kind == BK_STOP;

  lbf_break #(.SLOTS(BRK_SLOTS)) u_brk (
    .clk_i, .rst_ni, .tick_i, .arm_i(brk_arm), .active_o(brk_act)
  );

  always_comb begin
    if (!test_on) lb_d = tx_i;
    else begin
      lb_d = (kind == BK_START) ? tx_mod : tx_dly;
      if (inv)     lb_d = ~lb_d;
      if (brk_act) lb_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lb_q <= 1'b1;
    else if (tick_i) lb_q <= lb_d;
  end

  assign rx_o = cfg.loop_en ? lb_q : pin_rx_i;
endmodule

// File: rtl/lbf_loopback_chk.sv
module lbf_loopback_chk
  import lbf_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [31:0] cfg_rdata_o,
  input logic        tick_i,
  input logic [2:0]  bit_kind_i,
  input logic        tx_i,
  input logic        rx_o
);
  logic loop_on, key_ok, par_on, brk_on, no_shift, no_mask;
  assign loop_on  = cfg_rdata_o[LOOP_BIT];
  assign key_ok   = cfg_rdata_o[KEY_LSB +: 4] == TEST_KEY;
  assign par_on   = cfg_rdata_o[PAR_BIT];
  assign brk_on   = cfg_rdata_o[BRK_BIT];
  assign no_shift = cfg_rdata_o[SHIFT_LSB +: SHIFT_W] == '0;
  assign no_mask  = cfg_rdata_o[MASK_LSB +: MASK_W] == '0;

  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & ~WR_MASK) == 32'h0);

  a_r3_plain_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_on && !key_ok && tick_i && !cfg_we_i) |=> rx_o == $past(tx_i));

  a_r5_start_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_on && key_ok && no_mask && !brk_on && tick_i && !cfg_we_i
     && bit_kind_i == 3'd1) |=> rx_o == $past(tx_i));

  a_r8_parity_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_on && key_ok && par_on && !brk_on && no_shift && no_mask && tick_i
     && !cfg_we_i && bit_kind_i == 3'd3) |=> rx_o == !$past(tx_i));

  a_r9_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_on && key_ok && brk_on && no_shift && no_mask && tick_i
     && !cfg_we_i && bit_kind_i == 3'd4) |=> !rx_o);

  a_r11_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_on && !tick_i && !cfg_we_i) |=> $stable(rx_o));
endmodule

bind lbf_loopback lbf_loopback_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_rdata_o(cfg_rdata_o),
  .tick_i(tick_i), .bit_kind_i(bit_kind_i), .tx_i(tx_i), .rx_o(rx_o)
);

// File: tb/lbf_loopback_test.sv
`timescale 1ns/1ps
module lbf_loopback_test;
  localparam int OVS = 8, CTR = 4, FRAME = 11 * OVS, NIDLE = 96, NCAP = FRAME + NIDLE;
  localparam logic [31:0] LOOP = 32'h0001_0000, KEY = 32'h0000_000A;
  localparam logic [31:0] PAR = 32'h0000_1000, BRK = 32'h0000_2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, tick = 1'b0, center = 1'b0, tx = 1'b1, pin = 1'b1;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [2:0] kind = 3'd0;
  logic rx;
  logic cap [NCAP];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lbf_loopback #(.OVS(OVS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .tick_i(tick), .bit_kind_i(kind), .center_i(center),
    .tx_i(tx), .pin_rx_i(pin), .rx_o(rx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  function automatic logic ideal(int i, logic [7:0] d, bit pflip, bit skill);
    int b;
    if (i < 0 || i >= FRAME) return 1'b1;
    b = i / OVS;
    if (b == 0) return 1'b0;
    if (b <= 8) return d[b-1];
    if (b == 9) return (^d) ^ pflip;
    return !skill;
  endfunction

  task automatic slot(input logic [2:0] k, input logic v, input logic c, output logic r);
    @(negedge clk); kind = k; tx = v; center = c; tick = 1'b1;
    @(negedge clk); tick = 1'b0; r = rx;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    logic r;
    for (int i = 0; i < OVS; i++) slot(3'd0, 1'b1, 1'b0, r);
    for (int i = 0; i < NCAP; i++) begin
      int b;
      logic [2:0] k;
      b = i / OVS;
      k = (i >= FRAME) ? 3'd0 : (b == 0) ? 3'd1 : (b <= 8) ? 3'd2 : (b == 9) ? 3'd3 : 3'd4;
      slot(k, ideal(i, d, 0, 0), (i < FRAME) && (i % OVS == CTR), r);
      cap[i] = r;
    end
  endtask

  function automatic logic maj(int b);
    int s;
    s = int'(cap[b*OVS+CTR-1]) + int'(cap[b*OVS+CTR]) + int'(cap[b*OVS+CTR+1]);
    return s >= 2;
  endfunction

  task automatic decode(output logic [7:0] d, output bit perr, output bit ferr, output int lowrun);
    for (int b = 0; b < 8; b++) d[b] = maj(b + 1);
    perr = maj(9) != ^d;
    ferr = !maj(10);
    lowrun = 0;
    for (int i = 10 * OVS; i < NCAP; i++) begin
      if (cap[i] != 1'b0) break;
      lowrun++;
    end
  endtask

  task automatic t_reset;
    chk(cfg_rdata == 32'h0, "R1 reset", cfg_rdata, 0);
    pin = 1'b0; #1;
    chk(rx == 1'b0, "R2 pin low", rx, 0);
    pin = 1'b1; #1;
    chk(rx == 1'b1, "R2 pin high", rx, 1);
  endtask

  task automatic t_reserved;
    wr(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h0001_337F, "R1 reserved", cfg_rdata, 32'h0001_337F);
    wr(32'h0);
    chk(cfg_rdata == 32'h0, "R1 clear", cfg_rdata, 0);
  endtask

  task automatic t_pin_path;
    wr(KEY | PAR | BRK | 32'h370);
    @(negedge clk); pin = 1'b0; #1;
    chk(rx == 1'b0, "R2 faults ignored without loopback", rx, 0);
    pin = 1'b1; #1;
    chk(rx == 1'b1, "R2 follows pin", rx, 1);
  endtask

  task automatic t_wrong_key;
    int bad = 0;
    wr(LOOP | 32'h5 | PAR | BRK | 32'h130);
    send(8'hC3);
    for (int i = 0; i < NCAP; i++) if (cap[i] !== ideal(i, 8'hC3, 0, 0)) bad++;
    chk(bad == 0, "R3 wrong key unmodified", bad, 0);
  endtask

  task automatic t_latency;
    wr(LOOP | KEY);
    @(negedge clk); kind = 3'd1; tx = 1'b0; tick = 1'b1; #1;
    chk(rx == 1'b1, "R11 no change before edge", rx, 1);
    @(negedge clk); tick = 1'b0;
    chk(rx == 1'b0, "R11 updates after tick", rx, 0);
    tx = 1'b1; kind = 3'd0;
    @(negedge clk);
    chk(rx == 1'b0, "R11 held without tick", rx, 0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_shift(input int s);
    int bad = 0;
    wr(LOOP | KEY | (s << 4));
    send(8'hA5);
    for (int i = 0; i < NCAP; i++) begin
      logic e;
      e = (i < OVS) ? ideal(i, 8'hA5, 0, 0) : ideal(i - s, 8'hA5, 0, 0);
      if (cap[i] !== e) bad++;
    end
    chk(bad == 0, $sformatf("R4 shift %0d waveform", s), bad, 0);
    chk(cap[0] == 1'b0, $sformatf("R5 start undelayed shift %0d", s), cap[0], 0);
  endtask

  task automatic t_mask(input int m);
    int bad = 0;
    logic [7:0] d;
    bit pe, fe;
    int lr;
    wr(LOOP | KEY | (m << 8));
    send(8'h3C);
    for (int i = 0; i < NCAP; i++) begin
      logic e;
      e = ideal(i, 8'h3C, 0, 0);
      if (i < FRAME && (i % OVS) == CTR + m - 1) e = ~e;
      if (cap[i] !== e) bad++;
    end
    chk(bad == 0, $sformatf("R6 mask %0d position", m), bad, 0);
    decode(d, pe, fe, lr);
    chk(d == 8'h3C && !pe && !fe, $sformatf("R7 majority mask %0d", m), {pe, fe, d}, 8'h3C);
  endtask

  task automatic t_clean;
    logic [7:0] d;
    bit pe, fe;
    int lr;
    wr(LOOP | KEY);
    send(8'h96);
    decode(d, pe, fe, lr);
    chk(d == 8'h96 && !pe && !fe, "R3 R4 clean test loop", {pe, fe, d}, 8'h96);
  endtask

  task automatic t_parity;
    logic [7:0] d;
    bit pe, fe;
    int lr;
    wr(LOOP | KEY | PAR);
    send(8'h5A);
    decode(d, pe, fe, lr);
    chk(pe && !fe && d == 8'h5A, "R8 parity error only", {pe, fe, d}, 32'h25A);
    chk(lr < OVS, "R8 no break", lr, 0);
  endtask

  task automatic t_break;
    logic [7:0] d;
    bit pe, fe;
    int lr;
    wr(LOOP | KEY | BRK);
    send(8'h5A);
    decode(d, pe, fe, lr);
    chk(fe && !pe && d == 8'h5A, "R9 framing error", {pe, fe, d}, 32'h15A);
    chk(lr == 11 * OVS, "R10 break length", lr, 11 * OVS);
    chk(cap[FRAME + 10 * OVS] == 1'b1, "R10 line released", cap[FRAME + 10 * OVS], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_reserved;
    t_pin_path;
    t_wrong_key;
    t_latency;
    t_clean;
    t_shift(1);
    t_shift(4);
    t_shift(7);
    for (int m = 1; m <= 3; m++) t_mask(m);
    t_parity;
    t_break;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule